// File: doc/BRIEF.md
# Divider-Free Coefficient Quantizer with Block Transpose

This block quantizes a stream of signed transform coefficients that arrive as square blocks of 8 x 8 values, one value per accepted cycle in row order. A divider is never built. For every block position the elaborator turns the step size for that position into a fixed reciprocal, `floor(4096 / Q)`. The hardware multiplies the magnitude of the coefficient by that reciprocal. It then removes the 2^12 scale and rounds on the most significant discarded bit. The sign is restored afterwards, so positive and negative inputs round the same way.

The quantized values go into one half of a two-bank buffer while the other half streams out. The output order is the transpose of the arrival order: the block comes out column by column. A downstream entropy stage therefore receives the column organisation it expects, although the producer writes rows. The 64 step sizes are fixed at elaboration through one packed parameter. Their default is 1 everywhere, which passes coefficients through unchanged.

The read side is a two-state machine. `RD_IDLE` waits for a completed block. On the block-ready pulse it takes the transition *start* into `RD_DRAIN`, which emits 64 transposed values. At the 64th value the machine either takes *chain*, staying in `RD_DRAIN` and switching banks when the next block is already complete, or takes *finish* back to `RD_IDLE`.

Top module: `coef_quantizer_xpose`

## Requirements
- R1: While `rst_n` is low, and after its release until a block completes, `out_valid` and `out_first` are 0.
- R2: The step for position p, where p = 8*row + col in arrival order, is bits [8p+7:8p] of `QTAB`. The reciprocal for that position is floor(4096 / step).
- R3: Each output value equals sign(x) * floor((|x| * floor(4096/step) + 2048) / 4096), where x is the input coefficient at the source position.
- R4: With the default table (every step 1), every output equals its input coefficient, including -2048 and 2047.
- R5: The k-th output of a block (k = 0..63) carries the input at position 8*(k mod 8) + floor(k/8).
- R6: A sample with `in_valid` and `in_first` both high is written to position 0. Each further valid sample takes the next position, and the position wraps to 0 after 63. Cycles with `in_valid` low are ignored. A partial block that is cut short by `in_first` never appears at the output.
- R7: The first output of a block, marked by `out_first`, is visible after the second clock edge following the edge that accepts the block's 64th sample.
- R8: Each block leaves as 64 consecutive cycles with `out_valid` high. `out_first` is high only on the first of these cycles.
- R9: Blocks supplied back to back, with no idle cycle, leave back to back, each complete and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input coefficient is present |
| in_first | input | 1 | Marks the first coefficient of a block (position 0) |
| in_coef | input | COEF_W | Signed input coefficient |
| out_valid | output | 1 | Output coefficient is present |
| out_first | output | 1 | Marks the first output of a transposed block |
| out_coef | output | COEF_W | Signed quantized coefficient |

## Verification
A value written at position p is not seen until its whole block is complete. The first output of that block appears after the second edge that follows the edge accepting the 64th sample. The k-th output then follows k cycles later. The bench drives inputs on falling edges. For every completed block it records a target cycle equal to three rising edges after the drive of its last sample. Outputs are sampled on the falling edge, so `out_first` is compared against that target cycle. Expected values wait in a queue in transposed order and are popped one per valid output, so any missing or extra cycle inside a burst shows up as a data or continuity mismatch.

// File: rtl/cq_pkg.sv
package cq_pkg;

    typedef enum logic {
        RD_IDLE  = 1'b0,
        RD_DRAIN = 1'b1
    } rd_state_e;

    // Elaboration-time reciprocal of a quantizer step; a zero step acts as 1.
    function automatic int unsigned cq_recip(input int unsigned step, input int unsigned frac_w);
        int unsigned s;
        s = (step == 0) ? 1 : step;
        return (32'd1 << frac_w) / s;
    endfunction

endpackage

// File: rtl/cq_recip_mul.sv
module cq_recip_mul #(
    parameter int unsigned COEF_W = 12,
    parameter int unsigned FRAC_W = 12
) (
    input  logic signed [COEF_W-1:0] coef,
    input  logic        [FRAC_W:0]   rcp,
    output logic signed [COEF_W-1:0] qout
);
    localparam int unsigned PROD_W = COEF_W + FRAC_W + 2;
    localparam logic [PROD_W-1:0] HALF = PROD_W'(1) << (FRAC_W - 1);

    logic              neg;
    logic [COEF_W-1:0] mag;
    logic [PROD_W-1:0] prod;
    logic [COEF_W-1:0] mag_q;

    always_comb begin
        neg   = coef[COEF_W-1];
        mag   = neg ? (~coef + COEF_W'(1)) : coef;
        prod  = PROD_W'(mag) * PROD_W'(rcp);
        mag_q = COEF_W'((prod + HALF) >> FRAC_W);
        qout  = neg ? -$signed(mag_q) : $signed(mag_q);
    end

endmodule

// File: rtl/cq_wr_ctrl.sv
module cq_wr_ctrl #(
    parameter int unsigned IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_first,
    output logic [IDX_W-1:0] wr_pos,
    output logic             wr_bank,
    output logic             blk_rdy,
    output logic             rdy_bank
);
    logic [IDX_W-1:0] cnt;

    assign wr_pos = in_first ? '0 : cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            wr_bank  <= 1'b0;
            blk_rdy  <= 1'b0;
            rdy_bank <= 1'b0;
        end else begin
            blk_rdy <= 1'b0;
            if (in_valid) begin
                cnt <= wr_pos + IDX_W'(1);
                if (&wr_pos) begin
                    wr_bank  <= ~wr_bank;
                    blk_rdy  <= 1'b1;
                    rdy_bank <= wr_bank;
                end
            end
        end
    end

endmodule

// File: rtl/cq_pingpong.sv
module cq_pingpong #(
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned DATA_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wbank,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rbank,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned ENT = 1 << IDX_W;

    logic [DATA_W-1:0] mem [2][ENT];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wbank][widx] <= wdata;
        end
    end

    assign rdata = mem[rbank][ridx];

endmodule

// File: rtl/cq_rd_fsm.sv
module cq_rd_fsm
    import cq_pkg::*;
#(
    parameter int unsigned SIDE_LG = 3,
    parameter int unsigned DATA_W  = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       blk_rdy,
    input  logic                       rdy_bank,
    output logic                       rd_bank,
    output logic [2*SIDE_LG-1:0]       rd_addr,
    input  logic [DATA_W-1:0]          rd_data,
    output logic                       out_valid,
    output logic                       out_first,
    output logic signed [DATA_W-1:0]   out_coef
);
    localparam int unsigned IDX_W = 2 * SIDE_LG;

    rd_state_e        state, nxt;
    logic [IDX_W-1:0] rd_idx;
    logic             last, load;

    // Output k reads source position (k mod side) * side + k / side.
    assign rd_addr = {rd_idx[SIDE_LG-1:0], rd_idx[IDX_W-1:SIDE_LG]};
    assign last    = (state == RD_DRAIN) && (&rd_idx);
    assign load    = blk_rdy && ((state == RD_IDLE) || last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RD_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RD_IDLE:  if (blk_rdy)            nxt = RD_DRAIN;
            RD_DRAIN: if (last && !blk_rdy)   nxt = RD_IDLE;
            default:                          nxt = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_first <= 1'b0;
            out_coef  <= '0;
            rd_idx    <= '0;
            rd_bank   <= 1'b0;
        end else begin
            out_valid <= (state == RD_DRAIN);
            out_first <= (state == RD_DRAIN) && (rd_idx == '0);
            if (state == RD_DRAIN) begin
                out_coef <= $signed(rd_data);
            end
            if (load) begin
                rd_idx  <= '0;
                rd_bank <= rdy_bank;
            end else if (state == RD_DRAIN) begin
                rd_idx  <= rd_idx + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/coef_quantizer_xpose.sv
module coef_quantizer_xpose
    import cq_pkg::*;
#(
    parameter int unsigned COEF_W  = 12,
    parameter int unsigned SIDE_LG = 3,
    parameter int unsigned FRAC_W  = 12,
    parameter int unsigned QSTEP_W = 8,
    parameter logic [(1 << (2*SIDE_LG))*QSTEP_W-1:0] QTAB = {(1 << (2*SIDE_LG)){QSTEP_W'(1)}}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_first,
    input  logic signed [COEF_W-1:0] in_coef,
    output logic                     out_valid,
    output logic                     out_first,
    output logic signed [COEF_W-1:0] out_coef
);
    localparam int unsigned IDX_W = 2 * SIDE_LG;
    localparam int unsigned ENT   = 1 << IDX_W;
    localparam int unsigned RCP_W = FRAC_W + 1;

    logic [RCP_W-1:0]         rtab [ENT];
    logic [IDX_W-1:0]         wr_pos;
    logic                     wr_bank, blk_rdy, rdy_bank, rd_bank;
    logic [IDX_W-1:0]         rd_addr;
    logic [COEF_W-1:0]        rd_data;
    logic signed [COEF_W-1:0] q_val;

    for (genvar g = 0; g < ENT; g++) begin : g_rcp
        localparam int unsigned STEP = int'(QTAB[g*QSTEP_W +: QSTEP_W]);
        assign rtab[g] = RCP_W'(cq_recip(STEP, FRAC_W));
    end

    cq_wr_ctrl #(.IDX_W(IDX_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_first (in_first),
        .wr_pos   (wr_pos),
        .wr_bank  (wr_bank),
        .blk_rdy  (blk_rdy),
        .rdy_bank (rdy_bank)
    );

    cq_recip_mul #(.COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_mul (
        .coef (in_coef),
        .rcp  (rtab[wr_pos]),
        .qout (q_val)
    );

    cq_pingpong #(.IDX_W(IDX_W), .DATA_W(COEF_W)) u_buf (
        .clk   (clk),
        .we    (in_valid),
        .wbank (wr_bank),
        .widx  (wr_pos),
        .wdata (q_val),
        .rbank (rd_bank),
        .ridx  (rd_addr),
        .rdata (rd_data)
    );

    cq_rd_fsm #(.SIDE_LG(SIDE_LG), .DATA_W(COEF_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_rdy   (blk_rdy),
        .rdy_bank  (rdy_bank),
        .rd_bank   (rd_bank),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .out_valid (out_valid),
        .out_first (out_first),
        .out_coef  (out_coef)
    );

endmodule

// File: rtl/cq_checks.sv
module cq_checks #(
    parameter int unsigned SIDE_LG = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [2*SIDE_LG-1:0] wr_pos,
    input logic                 out_valid,
    input logic                 out_first
);
    localparam int unsigned IDX_W = 2 * SIDE_LG;
    localparam int unsigned ENT   = 1 << IDX_W;

    logic [IDX_W:0] run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= '0;
        end else if (out_valid) begin
            run <= out_first ? (IDX_W+1)'(1)
                 : ((run == (IDX_W+1)'(ENT)) ? run : run + (IDX_W+1)'(1));
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_first));

    assert_first_has_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_first |-> out_valid);

    assert_burst_unbroken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run != '0 && run < (IDX_W+1)'(ENT)) |-> (out_valid && !out_first));

    assert_first_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&wr_pos)) |-> ##3 out_first);

endmodule

bind coef_quantizer_xpose cq_checks #(.SIDE_LG(SIDE_LG)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .wr_pos    (wr_pos),
    .out_valid (out_valid),
    .out_first (out_first)
);

// File: tb/tb_coef_quantizer_xpose.sv
module tb_coef_quantizer_xpose;

    localparam int NPOS = 64;

    function automatic int qf(input int p);
        if (p == 0) return 2;
        if (p == 1) return 255;
        return ((p * 37) % 29) + 1;
    endfunction

    function automatic logic [NPOS*8-1:0] mk_tab();
        logic [NPOS*8-1:0] t;
        for (int p = 0; p < NPOS; p++) t[p*8 +: 8] = 8'(qf(p));
        return t;
    endfunction

    localparam logic [NPOS*8-1:0] TAB = mk_tab();

    // R2, R3: reciprocal form with symmetric rounding.
    function automatic int q_exp(input int x, input int step);
        int r, m, v;
        r = 4096 / step;
        m = (x < 0) ? -x : x;
        v = (m * r + 2048) / 4096;
        return (x < 0) ? -v : v;
    endfunction

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_first = 1'b0;
    logic signed [11:0] in_coef = '0;
    logic out_valid, out_first, outq_valid, outq_first;
    logic signed [11:0] out_coef, outq_coef;

    always #10 clk = ~clk;

    coef_quantizer_xpose dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first), .in_coef(in_coef),
        .out_valid(out_valid), .out_first(out_first), .out_coef(out_coef)
    );

    coef_quantizer_xpose #(.QTAB(TAB)) dut_q (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first), .in_coef(in_coef),
        .out_valid(outq_valid), .out_first(outq_first), .out_coef(outq_coef)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int exp_first_cyc = -1;
    int exp0[$];
    int exp1[$];
    int j0 = 0;
    int j1 = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (exp0.size() == 0) begin
                    check(1'b0, "R8 unexpected output", int'(out_coef), 0);
                end else begin
                    check(int'(out_coef) == exp0[0], "R4 R5 default-table value", int'(out_coef), exp0[0]);
                    void'(exp0.pop_front());
                end
                check(out_first == (j0 == 0), "R8 first marker", int'(out_first), int'(j0 == 0));
                if (out_first)
                    check(cyc == exp_first_cyc, "R7 first-output cycle", cyc, exp_first_cyc);
                j0 = (j0 + 1) % NPOS;
            end else if (j0 != 0) begin
                check(1'b0, "R8 R9 burst gap", 0, 1);
                j0 = 0;
            end
            if (outq_valid) begin
                if (exp1.size() == 0) begin
                    check(1'b0, "R8 unexpected output", int'(outq_coef), 0);
                end else begin
                    check(int'(outq_coef) == exp1[0], "R2 R3 R5 table value", int'(outq_coef), exp1[0]);
                    void'(exp1.pop_front());
                end
                j1 = (j1 + 1) % NPOS;
            end else if (j1 != 0) begin
                check(1'b0, "R8 R9 burst gap", 0, 1);
                j1 = 0;
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_first = 1'b0;
        end
    endtask

    task automatic send_block(input int vals[NPOS], input bit use_first, input int max_gap);
        for (int k = 0; k < NPOS; k++) begin
            if (max_gap > 0) idle(int'($urandom_range(max_gap, 0)));
            @(negedge clk);
            in_valid = 1'b1;
            in_first = use_first && (k == 0);
            in_coef  = 12'(vals[k]);
            if (k == NPOS - 1) begin
                exp_first_cyc = cyc + 3;
                for (int j = 0; j < NPOS; j++) begin
                    int src;
                    src = (j % 8) * 8 + j / 8;
                    exp0.push_back(q_exp(vals[src], 1));
                    exp1.push_back(q_exp(vals[src], qf(src)));
                end
            end
        end
    endtask

    task automatic rand_vals(output int vals[NPOS]);
        for (int k = 0; k < NPOS; k++) vals[k] = int'($urandom_range(4095, 0)) - 2048;
    endtask

    initial begin
        #(20ns * 150000);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int v[NPOS];
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check(!out_valid && !out_first, "R1 outputs during reset", int'(out_valid), 0);
        rst_n = 1'b1;
        idle(5);
        check(!out_valid && !outq_valid, "R1 quiet after reset", int'(out_valid), 0);

        // R6: partial block abandoned by a new first marker
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_first = (k == 0); in_coef = 12'sd999;
        end
        idle(6);
        check(!out_valid && !outq_valid, "R6 partial block produces nothing", int'(out_valid), 0);

        // R5: ramp makes the transpose visible
        for (int k = 0; k < NPOS; k++) v[k] = k * 31 - 1000;
        send_block(v, 1'b1, 0);
        idle(70);

        // R4: extremes
        for (int k = 0; k < NPOS; k++) v[k] = (k % 2 == 0) ? 2047 : -2048;
        send_block(v, 1'b1, 0);
        idle(70);

        // R3: rounding at half steps, both signs
        for (int k = 0; k < NPOS; k++) begin
            int h;
            h = qf(k) / 2 + ((k % 3) == 0 ? 0 : 1) + (k % 4) * qf(k);
            v[k] = (k % 2 == 1) ? -h : h;
        end
        v[0] = 3; v[8] = -3;
        send_block(v, 1'b1, 0);
        idle(70);

        // R6: gaps between samples
        rand_vals(v);
        send_block(v, 1'b1, 3);
        idle(70);

        // R9: back to back, last one without a first marker (R6 wrap)
        for (int b = 0; b < 4; b++) begin
            rand_vals(v);
            send_block(v, (b != 3), 0);
        end
        idle(80);

        // random blocks, mixed gaps
        for (int b = 0; b < 16; b++) begin
            rand_vals(v);
            send_block(v, 1'b1, (b % 3 == 0) ? 2 : 0);
            if (b % 2 == 1) idle(int'($urandom_range(40, 0)));
        end
        idle(150);

        check(exp0.size() == 0, "R8 R9 all blocks delivered", exp0.size(), 0);
        check(exp1.size() == 0, "R8 R9 all blocks delivered", exp1.size(), 0);
        finish_run();
    end

endmodule